// File: doc/BRIEF.md
# Multiplexed Cartridge ROM Bus Sequencer

This block makes a read-only cartridge ROM for a 16-bit host out of a synchronous memory and one set of 16 bidirectional pins. The host puts a word address on the cartridge bus and pulls one of two active-low window selects. The sequencer sees the select go low and opens the address-side buffer so the pins can be sampled. It then closes that buffer, reads one word from the memory port, and opens the data-side buffer to drive that word back onto the same pins. The word stays on the bus until the host lets the select go high again.

Each window covers 64 KB. The select that is low becomes bit 16 of the word address that goes to the memory. The address slot and the data slot never overlap. Two separate buffer enables give three bus states: address in, data out, and no access. If the host releases the select before the data slot is reached, the access is abandoned and a sticky error flag records that the sequencer was too slow.

Top module: `cart_rom_seq`

## Requirements
- R1: Both select inputs go through a SYNC_STAGES-flop synchronizer (value 1 means inactive). When the sequencer is idle and either synchronized select is low, `rd_buf_n` goes low on the next clock.
- R2: `rd_buf_n` stays low for SAMPLE_CYC cycles. On the clock that ends that slot, `pin_in` is captured as the low 16 address bits: pin 0 carries A0, which comes from the host's upper-byte strobe, and pins 15..1 carry A15..A1. Bit 16 is 1 when the synchronized high-window select `sel_hi_n` is low and 0 otherwise.
- R3: `rd_buf_n` and `wr_buf_n` are never low together, and `pin_oe` is high only while `wr_buf_n` is low.
- R4: After the address slot there is one cycle with `mem_rd` high and `mem_addr` equal to the captured address. This is followed by one cycle in which the word returned one cycle after the read is registered. Both buffer enables stay high during these two cycles.
- R5: In the data slot `wr_buf_n` is low, `pin_oe` is high and `pin_out` holds the fetched word unchanged. The slot lasts while at least one synchronized select is low. On the clock after both read high, `wr_buf_n` goes high and `pin_oe` goes low.
- R6: If both synchronized selects read high during the address slot, the read cycle or the load cycle, the sequencer returns to idle with both enables high, and `late_err` goes to 1 on that same clock.
- R7: `late_err` stays 1 until reset, including through later accesses that complete normally.
- R8: Two back-to-back word accesses at addresses 2 bytes apart, separated only by a brief select release, are each served with their own memory read and their own word.
- R9: During and after reset `rd_buf_n`=1, `wr_buf_n`=1, `pin_oe`=0, `mem_rd`=0 and `late_err`=0.
- R10: If both selects are low at the same time, the high window takes precedence and address bit 16 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel_lo_n | input | 1 | Active-low select for the low 64 KB window |
| sel_hi_n | input | 1 | Active-low select for the high 64 KB window |
| pin_in | input | DW | Shared pins seen through the address buffer |
| pin_out | output | DW | Word driven onto the shared pins |
| pin_oe | output | 1 | Output enable for `pin_out` |
| rd_buf_n | output | 1 | Active-low enable of the address-side buffer |
| wr_buf_n | output | 1 | Active-low enable of the data-side buffer |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | DW+1 | Word address to the memory |
| mem_rdata | input | DW | Memory read data, valid one cycle after `mem_rd` |
| late_err | output | 1 | Sticky flag: an access ended before data was driven |

## Verification
The bench builds the block with DW=16 and SYNC_STAGES=2, and it raises SAMPLE_CYC from its default of 2 to 3. The longer address slot lets short select pulses end the access in each of the three abortable phases: the address slot, the read cycle and the load cycle. A behavioural model runs the phases and the synchronizer delay, and the bench compares it with the outputs on every cycle. That comparison covers full accesses, back-to-back pairs, both-selects-low and the abort cases.

// File: rtl/cart_rom_pkg.sv
package cart_rom_pkg;

  // Sequencer phases; encoding is internal only
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_FETCH = 3'd2,
    PH_LOAD  = 3'd3,
    PH_DRIVE = 3'd4
  } phase_e;

  // Number of window selects
  localparam int unsigned NUM_SEL = 2;

endpackage

// File: rtl/cart_sel_sync.sv
module cart_sel_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  // Each bit gets its own flop chain; the reset value is 1 (inactive)
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], async_in[b]};
    end else begin : g_single
      always_comb chain_d = async_in[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign sync_out[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/cart_seq_ctrl.sv
module cart_seq_ctrl
  import cart_rom_pkg::*;
#(
  parameter int unsigned SAMPLE_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel_act,
  output phase_e phase,
  output logic   capture,
  output logic   load_word,
  output logic   late_err
);

  localparam int unsigned CNT_W = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             err_q, err_d;
  logic             abort;

  // Next-state logic
  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    capture   = 1'b0;
    load_word = 1'b0;
    abort     = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (sel_act) begin
          phase_d = PH_ADDR;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      PH_ADDR: begin
        if (!sel_act) begin
          abort   = 1'b1;
          phase_d = PH_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          capture = 1'b1;
          phase_d = PH_FETCH;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      PH_FETCH: begin
        if (!sel_act) begin
          abort   = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          phase_d = PH_LOAD;
        end
      end
      PH_LOAD: begin
        if (!sel_act) begin
          abort   = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          load_word = 1'b1;
          phase_d   = PH_DRIVE;
        end
      end
      PH_DRIVE: begin
        if (!sel_act) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
    err_d = err_q | abort;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      err_q   <= err_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign phase    = phase_q;
  assign late_err = err_q;

endmodule

// File: rtl/cart_bus_path.sv
module cart_bus_path #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          hi_win,
  input  logic          load_word,
  input  logic [DW-1:0] pin_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW:0]   addr_q,
  output logic [DW-1:0] data_q
);

  logic [DW:0]   addr_d;
  logic [DW-1:0] data_d;

  // Window select becomes the top address bit
  always_comb addr_d = {hi_win, pin_in};
  always_comb data_d = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (capture)   addr_q <= addr_d;
      if (load_word) data_q <= data_d;
    end
  end

endmodule

// File: rtl/cart_rom_seq.sv
module cart_rom_seq
  import cart_rom_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SAMPLE_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_lo_n,
  input  logic          sel_hi_n,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic          pin_oe,
  output logic          rd_buf_n,
  output logic          wr_buf_n,
  output logic          mem_rd,
  output logic [DW:0]   mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          late_err
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Select synchronizer: bit 1 = high window, bit 0 = low window
  logic [NUM_SEL-1:0] sel_raw, sel_sync;
  logic               sel_act, hi_win;

  assign sel_raw = {sel_hi_n, sel_lo_n};

  cart_sel_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_SEL)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (sel_raw),
    .sync_out (sel_sync)
  );

  assign sel_act = ~&sel_sync;
  assign hi_win  = ~sel_sync[1];

  phase_e phase;
  logic   capture, load_word;

  cart_seq_ctrl #(.SAMPLE_CYC(SAMPLE_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel_act   (sel_act),
    .phase     (phase),
    .capture   (capture),
    .load_word (load_word),
    .late_err  (late_err)
  );

  logic [DW:0]   addr_q;
  logic [DW-1:0] data_q;

  cart_bus_path #(.DW(DW)) u_path (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .capture   (capture),
    .hi_win    (hi_win),
    .load_word (load_word),
    .pin_in    (pin_in),
    .mem_rdata (mem_rdata),
    .addr_q    (addr_q),
    .data_q    (data_q)
  );

  // Bus-state decode from the registered phase
  assign rd_buf_n = (phase != PH_ADDR);
  assign wr_buf_n = (phase != PH_DRIVE);
  assign pin_oe   = (phase == PH_DRIVE);
  assign pin_out  = data_q;
  assign mem_rd   = (phase == PH_FETCH);
  assign mem_addr = addr_q;

endmodule

// File: rtl/cart_rom_seq_chk.sv
module cart_rom_seq_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_buf_n,
  input logic          wr_buf_n,
  input logic          pin_oe,
  input logic [DW-1:0] pin_out,
  input logic          mem_rd,
  input logic          late_err
);

  assert_excl_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_buf_n || wr_buf_n);

  assert_oe_needs_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> !wr_buf_n);

  assert_dead_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_buf_n |=> wr_buf_n);

  assert_fetch_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (rd_buf_n && wr_buf_n && !pin_oe));

  assert_drive_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_buf_n |=> (wr_buf_n || $stable(pin_out)));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    late_err |=> late_err);

  assert_one_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rd_buf_n, ~wr_buf_n, mem_rd}));

endmodule

bind cart_rom_seq cart_rom_seq_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_buf_n (rd_buf_n),
  .wr_buf_n (wr_buf_n),
  .pin_oe   (pin_oe),
  .pin_out  (pin_out),
  .mem_rd   (mem_rd),
  .late_err (late_err)
);

// File: tb/cart_rom_seq_test.sv
module cart_rom_seq_test;

  localparam int CLK_PERIOD = 8;
  localparam int DW         = 16;
  localparam int SYNC       = 2;
  localparam int SAMPLE     = 3;
  localparam int WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_lo_n = 1'b1;
  logic          sel_hi_n = 1'b1;
  logic [DW-1:0] host_addr = '0;
  logic [DW-1:0] pin_in;
  logic [DW-1:0] pin_out;
  logic          pin_oe, rd_buf_n, wr_buf_n, mem_rd, late_err;
  logic [DW:0]   mem_addr;
  logic [DW-1:0] mem_rdata;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pins show the host address only through the open address buffer
  assign pin_in = rd_buf_n ? '0 : host_addr;

  function automatic logic [DW-1:0] word_of(input logic [DW:0] a);
    return a[DW-1:0] ^ (a[DW] ? 16'hA5C3 : 16'h1E0F);
  endfunction

  // Memory with one cycle of read latency
  always_ff @(posedge clk) if (mem_rd) mem_rdata <= word_of(mem_addr);

  cart_rom_seq #(.DW(DW), .SYNC_STAGES(SYNC), .SAMPLE_CYC(SAMPLE)) uut (
    .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .rd_buf_n(rd_buf_n), .wr_buf_n(wr_buf_n), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .late_err(late_err)
  );

  // Behavioural reference: phase 0 idle, 1 address, 2 read, 3 load, 4 drive
  int          m_phase = 0;
  int          m_cnt   = 0;
  bit          m_err   = 0;
  bit          m_lo_q[$];
  bit          m_hi_q[$];
  logic [DW:0] m_addr  = '0;
  logic [DW-1:0] m_data = '0;
  int          served  = 0;
  logic [DW:0] last_fetch = '0;

  initial begin
    for (int i = 0; i < SYNC; i++) begin m_lo_q.push_back(1); m_hi_q.push_back(1); end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_err = 0;
      m_lo_q.delete(); m_hi_q.delete();
      for (int i = 0; i < SYNC; i++) begin m_lo_q.push_back(1); m_hi_q.push_back(1); end
    end else begin
      bit act;
      bit hi;
      act = !(m_lo_q[0] && m_hi_q[0]);
      hi  = !m_hi_q[0];
      case (m_phase)
        0: if (act) begin m_phase = 1; m_cnt = 0; end
        1: if (!act) begin m_phase = 0; m_err = 1; end
           else if (m_cnt == SAMPLE-1) begin m_addr = {hi, host_addr}; m_phase = 2; end
           else m_cnt++;
        2: if (!act) begin m_phase = 0; m_err = 1; end else m_phase = 3;
        3: if (!act) begin m_phase = 0; m_err = 1; end
           else begin m_data = word_of(m_addr); m_phase = 4; served++; end
        default: if (!act) m_phase = 0;
      endcase
      void'(m_lo_q.pop_front()); m_lo_q.push_back(sel_lo_n);
      void'(m_hi_q.pop_front()); m_hi_q.push_back(sel_hi_n);
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rd_buf_n == (m_phase != 1), "R1", "rd_buf_n", rd_buf_n, m_phase != 1);
      check(wr_buf_n == (m_phase != 4), "R5", "wr_buf_n", wr_buf_n, m_phase != 4);
      check(pin_oe == (m_phase == 4), "R5", "pin_oe", pin_oe, m_phase == 4);
      if (m_phase == 4) check(pin_out == m_data, "R5", "pin_out", pin_out, m_data);
      check(mem_rd == (m_phase == 2), "R4", "mem_rd", mem_rd, m_phase == 2);
      if (m_phase == 2) begin
        check(mem_addr == m_addr, "R2", "mem_addr", mem_addr, m_addr);
        last_fetch = mem_addr;
      end
      check(late_err == m_err, "R6", "late_err", late_err, m_err);
      check(rd_buf_n || wr_buf_n, "R3", "enable overlap", {rd_buf_n, wr_buf_n}, 2'b11);
    end
  end

  task automatic access(input bit lo, input bit hi, input logic [DW-1:0] a,
                        input int hold, input int gap);
    @(negedge clk);
    host_addr = a;
    if (lo) sel_lo_n = 1'b0;
    if (hi) sel_hi_n = 1'b0;
    repeat (hold) @(negedge clk);
    sel_lo_n = 1'b1; sel_hi_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    int base;
    // R9: reset state
    repeat (3) @(negedge clk);
    vectors++;
    if (!(rd_buf_n && wr_buf_n && !pin_oe && !mem_rd && !late_err)) begin
      fails++;
      $display("FAIL R9 reset outputs: actual %b expected 11000",
               {rd_buf_n, wr_buf_n, pin_oe, mem_rd, late_err});
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2 R5: single accesses in each window
    access(1, 0, 16'h0001, 12, 4);
    access(0, 1, 16'h8007, 10, 4);
    access(1, 0, 16'hF0F0, 15, 4);

    // R8: two word reads two bytes apart, back to back
    base = served;
    access(0, 1, 16'hF0F0, 10, 2);
    access(0, 1, 16'hF0F2, 10, 4);
    check(served - base == 2, "R8", "words served", served - base, 2);
    check(last_fetch == {1'b1, 16'hF0F2}, "R8", "second address", last_fetch, {1'b1, 16'hF0F2});

    // R10: both selects low picks the high window
    access(1, 1, 16'h1234, 10, 4);
    check(last_fetch[DW] == 1'b1, "R10", "window bit", last_fetch[DW], 1);

    // R6: aborts in address slot, read cycle and load cycle
    access(1, 0, 16'h5555, 2, 4);
    check(late_err == 1'b1, "R6", "late_err after abort", late_err, 1);
    access(0, 1, 16'h6666, 4, 4);
    access(1, 0, 16'h7777, 5, 4);

    // R7: flag survives a good access
    access(1, 0, 16'h0003, 12, 4);
    check(late_err == 1'b1, "R7", "late_err sticky", late_err, 1);

    // R9: reset clears the flag
    rst_n = 1'b0;
    @(negedge clk);
    check(late_err == 1'b0, "R9", "late_err after reset", late_err, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    access(0, 1, 16'hABCE, 11, 4);

    finish_run();
  end

endmodule